// File: doc/BRIEF.md
# Internal Oscillator Tuning Control

This block is the control register for an on-chip oscillator. A bus master writes one 8-bit word into it. The word holds a signed frequency trim code, a bit that enables a 4x frequency multiplier, and a bit that selects the source of the low-frequency clock. The block sends the trim code and the source select to the analog oscillator. It forwards the multiplier enable only while the clock configuration allows the multiplier to run. The same word, with the current effective values, can be read back at any time.

The multiplier is allowed only in one case. The primary clock configuration must be one of the two internal-oscillator codes, and the frequency-select field must pick the 4 MHz or the 8 MHz output. With the multiplier on, these give 16 MHz and 32 MHz. In every other case a write to the enable bit is dropped. If the allowing condition goes away later, the stored bit is cleared.

When the divided source is selected, the block also counts cycles of its 8 MHz clock with a free-running counter. It emits a one-cycle tick every 256 cycles, which gives 31.25 kHz. While the direct 31 kHz oscillator is selected, the counter is held at zero.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While reset is active, and after it is released, until the first write: `rd_data`, `pll_en`, `lf_src_sel`, `trim_code` and `lf_tick` are all 0.
- R2: A write loads `wr_data[4:0]` into `trim_code` on the clock edge that samples `wr_en`. The code is two's complement: 5'b00000 is the calibrated centre, 5'b01111 is the highest frequency and 5'b10000 is the lowest.
- R3: A write loads `wr_data[7]` into `lf_src_sel` on the same edge: 1 selects the 8 MHz clock divided by 256, and 0 selects the direct 31 kHz oscillator.
- R4: `wr_data[5]` is ignored, and `rd_data[5]` always reads 0.
- R5: A write with `wr_data[6]`=1 sets the multiplier enable when `cfg_code` is 4'b1000 or 4'b1001 and `freq_sel` is 3'b110 or 3'b111. `pll_en` is then 1 from the next cycle on.
- R6: A write with `wr_data[6]`=1 has no effect when those conditions do not hold. `pll_en` and `rd_data[6]` stay 0.
- R7: When the conditions stop holding while the enable is set, `pll_en` drops to 0 at once and the stored bit is cleared on the next edge. If the conditions return, the enable stays 0 until it is written again.
- R8: While `lf_src_sel` is 1, `lf_tick` is a one-cycle pulse. It is high on every 256th cycle, first in the 256th cycle after the edge that set the select.
- R9: While `lf_src_sel` is 0, `lf_tick` stays 0 and the divider restarts from zero. After the select is set again, the first tick comes 256 cycles later.
- R10: `rd_data` reads {`lf_src_sel`, `pll_en`, 1'b0, `trim_code`} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz internal oscillator clock; it also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| cfg_code | input | 4 | Primary clock configuration code |
| freq_sel | input | 3 | Internal oscillator frequency-select field |
| rd_data | output | 8 | Read-back of the control word with effective values |
| pll_en | output | 1 | Effective enable of the 4x multiplier |
| lf_src_sel | output | 1 | Low-frequency source select |
| trim_code | output | 5 | Signed frequency trim code |
| lf_tick | output | 1 | Divide-by-256 tick |

## Verification
Writes to the trim code, the source select and the enable show up one cycle after the edge that samples `wr_en`. A change of `cfg_code` or `freq_sel` reaches `pll_en` in the same cycle, and it clears the stored bit at the next edge. A tick comes out 256 cycles after the select is set. After `rst_n` rises, the internal reset adds two cycles before any write is taken. The bench drives inputs just after a rising edge, updates its own model on the rising edge and compares every output at the falling edge. Directed checks count ticks over exact windows of 256-cycle periods.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  localparam int WORD_W = 8;
  localparam int TRIM_W = 5;
  localparam int CFG_W  = 4;
  localparam int FSEL_W = 3;

  // bit positions within the control word
  localparam int LF_BIT   = 7;
  localparam int PLL_BIT  = 6;
  localparam int RSVD_BIT = 5;

  // configuration codes that place the internal oscillator as primary
  localparam logic [CFG_W-1:0] CFG_INT_A = 4'b1000;
  localparam logic [CFG_W-1:0] CFG_INT_B = 4'b1001;

  // frequency selections the multiplier accepts (4 MHz, 8 MHz)
  localparam logic [FSEL_W-1:0] FSEL_4M = 3'b110;
  localparam logic [FSEL_W-1:0] FSEL_8M = 3'b111;

  typedef struct packed {
    logic              lf_sel;
    logic              pll;
    logic              rsvd;
    logic [TRIM_W-1:0] trim;
  } osc_word_t;

  function automatic osc_word_t make_word(logic lf, logic pll, logic [TRIM_W-1:0] trim);
    osc_word_t w;
    w.lf_sel = lf;
    w.pll    = pll;
    w.rsvd   = 1'b0;
    w.trim   = trim;
    return w;
  endfunction

endpackage

// File: rtl/osc_trim_rstsync.sv
module osc_trim_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/osc_trim_qualify.sv
module osc_trim_qualify
  import osc_trim_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_code,
  input  logic [FSEL_W-1:0] freq_sel,
  output logic              pll_allow
);

  logic cfg_ok;
  logic fsel_ok;

  always_comb begin
    cfg_ok    = (cfg_code == CFG_INT_A) || (cfg_code == CFG_INT_B);
    fsel_ok   = (freq_sel == FSEL_4M) || (freq_sel == FSEL_8M);
    pll_allow = cfg_ok && fsel_ok;
  end

endmodule

// File: rtl/osc_trim_regs.sv
module osc_trim_regs
  import osc_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_lf,
  input  logic              wr_pll,
  input  logic [TRIM_W-1:0] wr_trim,
  input  logic              pll_allow,
  output logic              lf_q,
  output logic              pll_q,
  output logic [TRIM_W-1:0] trim_q
);

  logic              lf_d;
  logic              pll_d;
  logic [TRIM_W-1:0] trim_d;
  logic              word_ce;

  always_comb begin
    word_ce = wr_en;
    lf_d    = lf_q;
    trim_d  = trim_q;
    if (word_ce) begin
      lf_d   = wr_lf;
      trim_d = wr_trim;
    end
    // the enable either takes the written value or holds; it is dropped whenever not allowed
    pll_d = (word_ce ? wr_pll : pll_q) && pll_allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q   <= 1'b0;
      trim_q <= '0;
    end else if (word_ce) begin
      lf_q   <= lf_d;
      trim_q <= trim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q <= 1'b0;
    end else begin
      pll_q <= pll_d;
    end
  end

  // R2
  trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (trim_q == $past(wr_trim)));

  // R6
  pll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_q) |-> $past(wr_en && wr_pll && pll_allow));

  // R7
  pll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_allow |=> !pll_q);

endmodule

// File: rtl/osc_trim_lfdiv.sv
module osc_trim_lfdiv #(
  parameter int DIV_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam logic [DIV_BITS-1:0] CNT_TOP = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] cnt_q;
  logic [DIV_BITS-1:0] cnt_d;

  always_comb begin
    if (!en) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = en && (cnt_q == CNT_TOP);

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int DIV_BITS   = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CFG_W-1:0]  cfg_code,
  input  logic [FSEL_W-1:0] freq_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              pll_en,
  output logic              lf_src_sel,
  output logic [TRIM_W-1:0] trim_code,
  output logic              lf_tick
);

  logic              rst_n_int;
  logic              pll_allow;
  logic              lf_q;
  logic              pll_q;
  logic [TRIM_W-1:0] trim_q;
  osc_word_t         rd_word;

  osc_trim_rstsync #(.STAGES(SYNC_STAGE)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  osc_trim_qualify u_qualify (
    .cfg_code  (cfg_code),
    .freq_sel  (freq_sel),
    .pll_allow (pll_allow)
  );

  osc_trim_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wr_lf     (wr_data[LF_BIT]),
    .wr_pll    (wr_data[PLL_BIT]),
    .wr_trim   (wr_data[TRIM_W-1:0]),
    .pll_allow (pll_allow),
    .lf_q      (lf_q),
    .pll_q     (pll_q),
    .trim_q    (trim_q)
  );

  osc_trim_lfdiv #(.DIV_BITS(DIV_BITS)) u_lfdiv (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (lf_q),
    .tick  (lf_tick)
  );

  always_comb begin
    pll_en     = pll_q && pll_allow;
    lf_src_sel = lf_q;
    trim_code  = trim_q;
    rd_word    = make_word(lf_q, pll_en, trim_q);
    rd_data    = rd_word;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (rd_data == '0 && !lf_tick));

  // R3
  lf_load_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_en |=> (lf_src_sel == $past(wr_data[LF_BIT])));

endmodule

// File: tb/osc_trim_ctrl_bench.sv
module osc_trim_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] cfg_code = '0;
  logic [2:0] freq_sel = '0;
  logic [7:0] rd_data;
  logic       pll_en;
  logic       lf_src_sel;
  logic [4:0] trim_code;
  logic       lf_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  osc_trim_ctrl u_osc_trim_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_code(cfg_code), .freq_sel(freq_sel), .rd_data(rd_data),
    .pll_en(pll_en), .lf_src_sel(lf_src_sel), .trim_code(trim_code),
    .lf_tick(lf_tick)
  );

  // behavioural reference model
  int   rel = 0;
  bit   m_lf = 0;
  bit   m_pll = 0;
  int   m_trim = 0;
  int   m_cnt = 0;

  function automatic bit allowed(logic [3:0] c, logic [2:0] f);
    return (c == 4'd8 || c == 4'd9) && (f == 3'd6 || f == 3'd7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_lf = 0; m_pll = 0; m_trim = 0; m_cnt = 0;
    end else begin
      if (rel >= 2) begin
        if (m_lf) m_cnt = (m_cnt + 1) % 256; else m_cnt = 0;
        if (wr_en) begin
          m_lf   = wr_data[7];
          m_trim = int'(wr_data[4:0]);
          m_pll  = wr_data[6] && allowed(cfg_code, freq_sel);
        end else begin
          m_pll  = m_pll && allowed(cfg_code, freq_sel);
        end
      end
      if (rel < 2) rel++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      bit e_pll;
      e_pll = m_pll && allowed(cfg_code, freq_sel);
      check("R2 trim_code", int'(trim_code), m_trim);
      check("R3 lf_src_sel", int'(lf_src_sel), int'(m_lf));
      check("R4 rd_data[5]", int'(rd_data[5]), 0);
      check("R5 R6 R7 pll_en", int'(pll_en), int'(e_pll));
      check("R8 R9 lf_tick", int'(lf_tick), int'(m_lf && m_cnt == 255));
      check("R10 rd_data", int'(rd_data), int'({m_lf, e_pll, 1'b0, m_trim[4:0]}));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic write(logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_cfg(logic [3:0] c, logic [2:0] f);
    @(posedge clk); #2;
    cfg_code = c; freq_sel = f;
  endtask

  task automatic count_ticks(int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (lf_tick) cnt++;
    end
  endtask

  initial begin
    int t;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 during reset
    check("R1 rd_data in reset", int'(rd_data), 0);
    check("R1 lf_tick in reset", int'(lf_tick), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check("R1 rd_data after release", int'(rd_data), 0);

    // R2 trim extremes
    write(8'h0F);
    @(negedge clk); #1;
    check("R2 trim max", int'(trim_code), 15);
    write(8'h10);
    @(negedge clk); #1;
    check("R2 trim min", int'(trim_code), 16);

    // R5 qualifying configuration
    set_cfg(4'b1001, 3'b111);
    write(8'h4F);
    @(negedge clk); #1;
    check("R5 pll set", int'(pll_en), 1);
    check("R10 read word", int'(rd_data), 8'h4F);

    // R7 lose and regain qualification
    set_cfg(4'b1001, 3'b101);
    @(negedge clk); #1;
    check("R7 pll drops at once", int'(pll_en), 0);
    set_cfg(4'b1001, 3'b111);
    @(negedge clk); #1;
    check("R7 pll stays cleared", int'(pll_en), 0);

    // R6 write blocked by configuration
    set_cfg(4'b0000, 3'b111);
    write(8'h40);
    set_cfg(4'b1001, 3'b111);
    @(negedge clk); #1;
    check("R6 dropped write (cfg)", int'(rd_data[6]), 0);
    set_cfg(4'b1000, 3'b100);
    write(8'h40);
    set_cfg(4'b1000, 3'b110);
    @(negedge clk); #1;
    check("R6 dropped write (fsel)", int'(pll_en), 0);

    // R4 bit 5 ignored, other code pair
    write(8'h6A);
    @(negedge clk); #1;
    check("R4 bit5 reads zero", int'(rd_data), 8'h4A);
    check("R5 pll set 1000/110", int'(pll_en), 1);

    // R8 divider ticks
    write(8'h90);
    count_ticks(512, t);
    check("R8 ticks in 512 cycles", t, 2);

    // R9 held while direct source
    write(8'h10);
    count_ticks(300, t);
    check("R9 no ticks", t, 0);
    write(8'h80);
    count_ticks(255, t);
    check("R9 restart no early tick", t, 0);
    count_ticks(1, t);
    check("R9 first tick after restart", t, 1);

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule